// File: doc/BRIEF.md
# Interrupt Shadow Inhibit Controller

This block decides, at every instruction boundary, whether a pending interrupt may be taken there. Some instructions open a one-instruction shadow when they retire. While that shadow covers a boundary, interrupt recognition is held off. A stack-segment load opens a shadow that holds off both maskable and non-maskable requests. An interrupt-enable instruction opens a shadow that holds off maskable requests only.

The retire stage drives a retire strobe together with two decode flags that describe the retiring instruction. The interrupt logic supplies the two pending request lines. The block returns one accept signal for each request class. An accept signal is high only in a retire cycle, and only when the boundary closing that instruction may be used to take the request.

Shadow-creating instructions can retire back to back. In that case the second one never extends the window: the shadow closes at the boundary after the second instruction. Choosing priority between the two classes, vectoring, and storing the interrupt-enable flag all belong to other blocks.

Top module: `interrupt_shadow_gate`

## Requirements
- R1: After reset no shadow is active, so the first retire with a request pending accepts it.
- R2: `intAccept` and `nmiAccept` are high only in a cycle where `retire` is high and the matching pending line is high.
- R3: A retire with `isStackLoad` high and no shadow active holds both accept outputs low in that cycle, whatever is pending.
- R4: A retire with `isIntEnable` high, `isStackLoad` low and no shadow active holds `intAccept` low in that cycle, while a pending non-maskable request is still accepted.
- R5: The shadow covers exactly one boundary. At the next retire after an arming retire, pending requests of both classes are accepted.
- R6: A shadow-creating retire while a shadow is already active does not re-arm it. Requests pending at that boundary are accepted, and so are requests pending at the retire that follows it.
- R7: When `isStackLoad` and `isIntEnable` are both high on an arming retire, the shadow takes the stack-load kind and blocks both classes.
- R8: Cycles with `retire` low do not change the shadow. A shadow armed before a gap is still consumed by the next retire after it.
- R9: A retire of an ordinary instruction with no shadow active accepts each pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retire | input | 1 | An instruction completes this cycle |
| isStackLoad | input | 1 | The retiring instruction loads the stack segment |
| isIntEnable | input | 1 | The retiring instruction sets the interrupt-enable flag |
| intPending | input | 1 | Maskable interrupt request pending |
| nmiPending | input | 1 | Non-maskable interrupt request pending |
| intAccept | output | 1 | Maskable request may be taken at this boundary |
| nmiAccept | output | 1 | Non-maskable request may be taken at this boundary |

## Verification
The random part mixes plain retires, stack-load retires, interrupt-enable retires, and retires with both flags set. Requests arrive at random and idle gaps fall between retires. This tells apart shadows that block one request class from shadows that block both, and it shows whether the shadow survives non-retire cycles. Directed sequences cover the states that random stimulus reaches rarely. Back-to-back arming retires show whether the design wrongly re-arms. An arm followed by a long idle gap checks that the shadow is consumed by a retire and not by time. The first retire after reset checks the reset state.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  // Kind of shadow currently held; SH_NONE means no shadow is active.
  typedef enum logic [1:0] {
    SH_NONE = 2'b00,
    SH_IE   = 2'b01,
    SH_SS   = 2'b10
  } shadowKind_t;

  // Strobes from the control side to the shadow state register.
  typedef struct packed {
    logic arm;    // open a new shadow at this boundary
    logic armSs;  // the new shadow is of the stack-load kind
    logic clear;  // close the active shadow at this boundary
  } shadowStrobes_t;

endpackage

// File: rtl/shadow_ctrl.sv
module shadow_ctrl
  import shadow_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           retire,
  input  logic           isStackLoad,
  input  logic           isIntEnable,
  input  logic           intPending,
  input  logic           nmiPending,
  input  shadowKind_t    shadowKind,
  output shadowStrobes_t strobes,
  output logic           intAccept,
  output logic           nmiAccept
);

  logic shadowActive;
  logic armsShadow;
  logic blockInt;
  logic blockNmi;

  assign shadowActive = (shadowKind != SH_NONE);
  assign armsShadow   = isStackLoad | isIntEnable;

  always_comb begin
    strobes       = '0;
    strobes.clear = retire & shadowActive;
    // A shadow-creating retire inside an active shadow is not re-armed.
    strobes.arm   = retire & ~shadowActive & armsShadow;
    strobes.armSs = retire & ~shadowActive & isStackLoad;
  end

  // The boundary that closes an arming instruction is the one the shadow covers.
  assign blockInt = strobes.arm;
  assign blockNmi = strobes.armSs;

  assign intAccept = retire & intPending & ~blockInt;
  assign nmiAccept = retire & nmiPending & ~blockNmi;

  p_accept_on_retire_r2: assert property (@(posedge clk) disable iff (!rstN)
    (intAccept | nmiAccept) |-> retire);

  p_ss_blocks_all_r3: assert property (@(posedge clk) disable iff (!rstN)
    (retire && isStackLoad && shadowKind == SH_NONE) |-> (!intAccept && !nmiAccept));

  p_ie_passes_nmi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (retire && isIntEnable && !isStackLoad && nmiPending && shadowKind == SH_NONE)
      |-> (nmiAccept && !intAccept));

  p_chain_open_r6: assert property (@(posedge clk) disable iff (!rstN)
    (retire && shadowKind != SH_NONE && intPending) |-> intAccept);

endmodule

// File: rtl/shadow_state.sv
module shadow_state
  import shadow_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  shadowStrobes_t strobes,
  output shadowKind_t    shadowKind
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowKind <= SH_NONE;
    end else if (strobes.clear) begin
      shadowKind <= SH_NONE;
    end else if (strobes.arm) begin
      shadowKind <= strobes.armSs ? SH_SS : SH_IE;
    end
  end

  p_one_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    (shadowKind != SH_NONE && strobes.clear) |=> (shadowKind == SH_NONE));

  p_ss_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.arm && strobes.armSs) |=> (shadowKind == SH_SS));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.arm && !strobes.clear) |=> $stable(shadowKind));

  p_legal_kind_r1: assert property (@(posedge clk) disable iff (!rstN)
    shadowKind != 2'b11);

endmodule

// File: rtl/interrupt_shadow_gate.sv
module interrupt_shadow_gate
  import shadow_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic retire,
  input  logic isStackLoad,
  input  logic isIntEnable,
  input  logic intPending,
  input  logic nmiPending,
  output logic intAccept,
  output logic nmiAccept
);

  shadowStrobes_t strobes;
  shadowKind_t    shadowKind;

  shadow_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .retire      (retire),
    .isStackLoad (isStackLoad),
    .isIntEnable (isIntEnable),
    .intPending  (intPending),
    .nmiPending  (nmiPending),
    .shadowKind  (shadowKind),
    .strobes     (strobes),
    .intAccept   (intAccept),
    .nmiAccept   (nmiAccept)
  );

  shadow_state i_state (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .shadowKind (shadowKind)
  );

endmodule

// File: tb/test_interrupt_shadow_gate.sv
`timescale 1ns/1ps
module test_interrupt_shadow_gate;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic retire = 1'b0, isStackLoad = 1'b0, isIntEnable = 1'b0;
  logic intPending = 1'b0, nmiPending = 1'b0;
  logic intAccept, nmiAccept;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference state: 0 none, 1 enable kind, 2 stack-load kind.
  int mKind = 0;

  always #2 clk = ~clk;

  interrupt_shadow_gate i_interrupt_shadow_gate (
    .clk(clk), .rstN(rstN), .retire(retire), .isStackLoad(isStackLoad),
    .isIntEnable(isIntEnable), .intPending(intPending), .nmiPending(nmiPending),
    .intAccept(intAccept), .nmiAccept(nmiAccept)
  );

  function automatic bit armNow();
    return retire && (mKind == 0) && (isStackLoad || isIntEnable);
  endfunction

  function automatic bit expInt();
    return retire && intPending && !armNow();
  endfunction

  function automatic bit expNmi();
    return retire && nmiPending && !(armNow() && isStackLoad);
  endfunction

  function automatic string pickTag();
    if (!retire) return (mKind != 0) ? "R8" : "R2";
    if (armNow() && isStackLoad && isIntEnable) return "R7";
    if (armNow() && isStackLoad) return "R3";
    if (armNow()) return "R4";
    if (mKind != 0 && (isStackLoad || isIntEnable)) return "R6";
    if (mKind != 0) return "R5";
    return "R9";
  endfunction

  task automatic checkBit(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, compare just after, then advance the model.
  task automatic step(bit r, bit ss, bit ie, bit ip, bit np, string forceTag);
    string tag;
    @(negedge clk);
    retire = r; isStackLoad = ss; isIntEnable = ie;
    intPending = ip; nmiPending = np;
    #1;
    tag = (forceTag != "") ? forceTag : pickTag();
    checkBit(tag, "intAccept", intAccept, expInt());
    checkBit(tag, "nmiAccept", nmiAccept, expNmi());
    if (retire) begin
      if (mKind != 0) mKind = 0;
      else if (isStackLoad) mKind = 2;
      else if (isIntEnable) mKind = 1;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mKind = 0;

    // R1: fresh reset, first retire with both requests pending is accepted
    step(1, 0, 0, 1, 1, "R1");
    // R3 then R5: stack-load arm, then consumed
    step(1, 1, 0, 1, 1, "");
    step(1, 0, 0, 1, 1, "");
    // R4 then R5
    step(1, 0, 1, 1, 1, "");
    step(1, 0, 0, 1, 1, "");
    // R6: chained enable, stack-load, stack-load
    step(1, 0, 1, 1, 1, "");
    step(1, 1, 0, 1, 1, "");
    step(1, 1, 0, 1, 1, "");
    step(1, 0, 0, 1, 1, "");
    // R7: both flags on an arming retire
    step(1, 1, 1, 1, 1, "");
    step(1, 0, 0, 1, 1, "");
    // R8: arm, long idle gap with requests, then retire consumes the shadow
    step(1, 1, 0, 0, 0, "");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1, "");
    step(1, 0, 0, 1, 1, "R8");
    step(1, 0, 0, 1, 1, "R9");

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit r  = ($urandom % 100) < 65;
      bit ss = ($urandom % 100) < 20;
      bit ie = ($urandom % 100) < 20;
      bit ip = ($urandom % 100) < 55;
      bit np = ($urandom % 100) < 40;
      step(r, ss, ie, ip, np, "");
    end

    // R1: reset in the middle of an armed shadow clears it
    step(1, 1, 0, 0, 0, "");
    @(negedge clk);
    rstN = 1'b0;
    retire = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    mKind = 0;
    step(1, 0, 0, 1, 1, "R1");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule